// File: doc/BRIEF.md
# Half-Memory Symmetric Partial-Product Table

This block holds the partial-product words for one tap group of a multiplier-free adaptive filter built on distributed arithmetic. For such a table, the word at a bit-inverted address is the negation of the word at the original address. The block therefore keeps only half of a full table: 2^(R-1) words for an R-bit address. The top address bit never reaches storage. It selects whether the remaining bits are inverted before indexing. It also selects whether the data is two's-complement negated, both on the way into storage and on the way out.

A caller sends requests on a valid/ready stream. Each request carries an R-bit address, an operation code and an update value. It gets back one response per accepted request on a second valid/ready stream. A read returns the partial product for the address. An update adds the update value to that partial product in one clock (read-modify-write) and returns the new value as seen at the requested address.

Back-pressure works as follows. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle. A pending response stays valid and unchanged until `rsp_ready` is seen high.

Top module: `sym_pp_table`

## Requirements
- R1: Storage holds 2^(ADDR_W-1) words, and reset clears every word to zero, so every one of the 2^ADDR_W addresses reads as zero after reset.
- R2: A read whose address MSB is 0 indexes storage with the lower ADDR_W-1 bits as they are and returns the stored word unchanged.
- R3: A read whose address MSB is 1 indexes storage with the lower ADDR_W-1 bits inverted and returns the negated stored word, so complementary addresses read as negations of each other; with ADDR_W=3 and entries built as sums of plus or minus half weights (bit 2 selects the sign of w0, bit 0 that of w2), address 111 reads as the negation of 000.
- R4: An update whose address MSB is 0 adds the update value to the word at the lower ADDR_W-1 bits; the addition saturates to the signed DATA_W range, and the response carries the new word.
- R5: An update whose address MSB is 1 negates the update value, adds it to the word at the inverted lower bits with saturation, and responds with the negation of the new word.
- R6: Negating the most negative value, on either the update path or the output path, yields the most positive value.
- R7: A read-modify-write completes in the accepting clock, and the next request, even one accepted on the very next edge, sees the updated word.
- R8: A request is accepted when req_valid and req_ready are both high; rsp_valid rises on the accepting edge; while rsp_valid is high and rsp_ready is low, rsp_data holds and req_ready is low.
- R9: req_op 0 selects read and 1 selects update; a read leaves every stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 1 | 0 = read, 1 = update |
| req_addr | input | ADDR_W | Full table address, MSB steers folding |
| req_upd | input | DATA_W | Signed update value, used by updates |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response this cycle |
| rsp_data | output | DATA_W | Signed partial product at the requested address |

## Verification
On every cycle, the embedded properties check the following:
- an accepted request always yields a response on the next edge;
- a stalled response stays stable;
- a plain read passes the stored word through;
- a folded read returns its negation;
- a write lands in the indexed word;
- an idle cycle leaves that word alone.

Only the bench scenarios can show the arithmetic content. That covers the saturation points of the add and of the negation. It covers symmetry across whole tables built from weights, and the accumulation over long update sequences at every address. It also covers the zero contents after reset.

// File: rtl/sym_pp_pkg.sv
package sym_pp_pkg;

  typedef enum logic {
    OP_READ   = 1'b0,
    OP_UPDATE = 1'b1
  } pp_op_e;

endpackage

// File: rtl/ppt_addr_fold.sv
module ppt_addr_fold #(
  parameter int ADDR_W = 3,
  localparam int IDX_W = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              neg
);
  // Top bit picks the mirrored half: invert the rest to reach the stored twin.
  always_comb begin
    neg = addr[ADDR_W-1];
    idx = neg ? ~addr[IDX_W-1:0] : addr[IDX_W-1:0];
  end
endmodule

// File: rtl/ppt_cond_neg.sv
module ppt_cond_neg #(
  parameter int DATA_W = 16
) (
  input  logic              neg,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};

  always_comb begin
    if (!neg)             dout = din;
    else if (din == MIN_V) dout = MAX_V;
    else                  dout = ~din + 1'b1;
  end
endmodule

// File: rtl/ppt_sat_add.sv
module ppt_sat_add #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum
);
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W:0] wide;

  always_comb begin
    wide = {a[DATA_W-1], a} + {b[DATA_W-1], b};
    if (wide[DATA_W] != wide[DATA_W-1])
      sum = wide[DATA_W] ? MIN_V : MAX_V;
    else
      sum = wide[DATA_W-1:0];
  end
endmodule

// File: rtl/ppt_store.sv
module ppt_store #(
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];

  // R7: a write is visible in its word on the following cycle
  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_idx)] == $past(wr_data));

  // R9: without a write the addressed word holds
  p_idle_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> mem[$past(rd_idx)] == $past(rd_data));
endmodule

// File: rtl/sym_pp_table.sv
module sym_pp_table
  import sym_pp_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_upd,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int IDX_W = ADDR_W - 1;
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  pp_op_e            op;
  logic              accept;
  logic [IDX_W-1:0]  idx;
  logic              neg;
  logic [DATA_W-1:0] stored;
  logic [DATA_W-1:0] upd_adj;
  logic [DATA_W-1:0] new_word;
  logic [DATA_W-1:0] result;
  logic [DATA_W-1:0] out_val;
  logic              wr_en;

  assign op        = pp_op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && (op == OP_UPDATE);

  ppt_addr_fold #(.ADDR_W(ADDR_W)) u_fold (
    .addr (req_addr),
    .idx  (idx),
    .neg  (neg)
  );

  ppt_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (idx),
    .rd_data (stored),
    .wr_en   (wr_en),
    .wr_idx  (idx),
    .wr_data (new_word)
  );

  // Input-side complementor: update folded into the stored half.
  ppt_cond_neg #(.DATA_W(DATA_W)) u_neg_in (
    .neg  (neg),
    .din  (req_upd),
    .dout (upd_adj)
  );

  ppt_sat_add #(.DATA_W(DATA_W)) u_add (
    .a   (stored),
    .b   (upd_adj),
    .sum (new_word)
  );

  assign result = (op == OP_UPDATE) ? new_word : stored;

  // Output-side complementor: unfold back to the requested address.
  ppt_cond_neg #(.DATA_W(DATA_W)) u_neg_out (
    .neg  (neg),
    .din  (result),
    .dout (out_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= out_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R8: every accepted request produces a response on the next edge
  p_accept_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  // R8: a stalled response neither drops nor changes
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R2: plain-half read passes the stored word through
  p_plain_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op == OP_READ) && !neg |=> rsp_data == $past(stored));

  // R3: mirrored-half read returns the negated stored word
  p_mirror_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op == OP_READ) && neg && (stored != MIN_V)
      |=> rsp_data == (~$past(stored) + 1'b1));
endmodule

// File: tb/sym_pp_table_tb.sv
module sym_pp_table_tb_top;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int MAXV = 32767;
  localparam int MINV = -32768;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_op = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_upd = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;

  int nchk = 0;
  int nfail = 0;
  int h [4];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sym_pp_table #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_upd(req_upd),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  function automatic int sneg(int x);
    return (x == MINV) ? MAXV : -x;
  endfunction

  function automatic int sadd(int a, int b);
    int s = a + b;
    if (s > MAXV) return MAXV;
    if (s < MINV) return MINV;
    return s;
  endfunction

  function automatic int ix(int a);
    return a[2] ? (~a) & 3 : a & 3;
  endfunction

  // expected response; applies update to the model
  function automatic int model(bit op, int a, int u);
    int i = ix(a);
    if (op) h[i] = sadd(h[i], a[2] ? sneg(u) : u);
    return a[2] ? sneg(h[i]) : h[i];
  endfunction

  task automatic chk(string rq, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic xact(bit op, int a, int u, string rq);
    int e;
    e = model(op, a, u);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a[AW-1:0]; req_upd = u[DW-1:0];
    @(negedge clk);
    req_valid = 1'b0;
    chk({rq, " valid"}, int'(rsp_valid), 1);
    chk(rq, $signed(rsp_data), e);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int w [3];
    int e1, e2, f;
    for (int i = 0; i < 4; i++) h[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle after reset", int'(rsp_valid), 0);

    // R1: all addresses zero after reset
    for (int a = 0; a < 8; a++) xact(1'b0, a, 0, "R1");

    // R3: build table from half weights at plain addresses, read all eight
    w[0] = 1000; w[1] = 600; w[2] = -200;
    for (int a = 0; a < 4; a++) begin
      f = (a[2] ? 1 : -1) * w[0] / 2 + (a[1] ? 1 : -1) * w[1] / 2 + (a[0] ? 1 : -1) * w[2] / 2;
      xact(1'b1, a, f, "R4 build");
    end
    for (int a = 0; a < 8; a++) begin
      f = (a[2] ? 1 : -1) * w[0] / 2 + (a[1] ? 1 : -1) * w[1] / 2 + (a[0] ? 1 : -1) * w[2] / 2;
      void'(model(1'b0, a, 0));
      @(negedge clk);
      req_valid = 1'b1; req_op = 1'b0; req_addr = a[AW-1:0];
      @(negedge clk);
      req_valid = 1'b0;
      chk(a[2] ? "R3 table" : "R2 table", $signed(rsp_data), f);
    end

    // R4/R5/R6: update sweep over every address with edge values
    for (int a = 0; a < 8; a++) begin
      xact(1'b1, a, 1, a[2] ? "R5" : "R4");
      xact(1'b1, a, -1234, a[2] ? "R5" : "R4");
      xact(1'b1, a, 32767, a[2] ? "R5 sat" : "R4 sat");
      xact(1'b1, a, -32768, a[2] ? "R6 neg-in" : "R4 sat");
      xact(1'b1, a, -32768, a[2] ? "R6 neg-in" : "R4 sat");
      xact(1'b1, a, 77, a[2] ? "R5" : "R4");
      // R9: reads everywhere after each address leave model unchanged
      for (int b = 0; b < 8; b++) xact(1'b0, b, 999, "R9");
    end

    // R6: drive word 0 to the minimum, read mirrored address 7
    xact(1'b1, 0, -32768, "R4");
    xact(1'b1, 0, -32768, "R4");
    xact(1'b0, 0, 0, "R2 min");
    chk("R6 stored min", h[0], MINV);
    xact(1'b0, 7, 0, "R6 neg-out");
    chk("R6 out max", h[0] == MINV ? MAXV : 0, MAXV);

    // R7: back-to-back update then read of the same word
    e1 = model(1'b1, 1, 100);
    @(negedge clk);
    req_valid = 1'b1; req_op = 1'b1; req_addr = 3'd1; req_upd = 16'd100;
    @(negedge clk);
    chk("R7 update", $signed(rsp_data), e1);
    e2 = model(1'b0, 6, 0);
    req_op = 1'b0; req_addr = 3'd6;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 next-cycle read", $signed(rsp_data), e2);

    // R8: back-pressure
    e1 = model(1'b0, 2, 0);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_op = 1'b0; req_addr = 3'd2;
    @(negedge clk);
    e2 = model(1'b0, 5, 0);
    req_addr = 3'd5;
    for (int k = 0; k < 3; k++) begin
      chk("R8 held valid", int'(rsp_valid), 1);
      chk("R8 held data", $signed(rsp_data), e1);
      chk("R8 not ready", int'(req_ready), 0);
      if (k < 2) @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 second rsp", $signed(rsp_data), e2);
    @(negedge clk);
    chk("R8 drained", int'(rsp_valid), 0);

    summary();
  end
endmodule